// File: doc/BRIEF.md
# Wake-Up Pin Detector Bank

This block watches a small set of asynchronous wake-up pins and records which of them has made its active transition. Each pin has its own active polarity and a two-bit pull setting. Each pin has a sticky event flag that software clears by writing a one to it. Two processors each keep their own enable mask over the pins. A pin whose flag is set raises the wake request of every processor that enabled it. It also drives its own interrupt line.

Configuration is held inside the block and written through a narrow write port. A select code picks one of four targets: the control word with polarity and pull, processor A's mask, processor B's mask, or the write-one-to-clear flag register. The pull settings are only presented on an output for the pad ring; the resistors themselves live elsewhere. Software changes a pin in a fixed order: mask it, rewrite polarity and pull, clear its flag, unmask it. Detection works on edges of the synchronised pin, so a polarity change alone never raises a flag.

Top module: `wkup_pin_bank`

## Requirements
- R1: After reset all flags, interrupt lines, wake requests and pull outputs are 0, and every pin's polarity is high-active.
- R2: With polarity high, a 0-to-1 change on an enabled pin sets its flag on the third rising clock edge after the change, not before; a pin held high does not set the flag again once it is cleared.
- R3: With polarity low, a 1-to-0 change on an enabled pin sets its flag with the same latency, and the opposite transition sets nothing.
- R4: A flag stays set until a clear write (select code 3) carries a one in that pin's bit position (bit i for pin i); zero bits in the clear write leave flags unchanged.
- R5: When a pin's active transition and a clear write for the same pin take effect on the same clock edge, the flag ends set.
- R6: An active transition on a pin that is disabled in both masks sets no flag.
- R7: wake_req_a is 1 exactly when some set flag is enabled in mask A (select code 1, bit i for pin i), and wake_req_b likewise for mask B (select code 2).
- R8: Interrupt line i is 1 exactly when flag i is set and pin i is enabled in at least one mask.
- R9: Rewriting a pin's polarity while the pin level is steady never sets its flag.
- R10: A control write (select code 0) sets polarity from bits [5:0] (bit i for pin i, 1 = high-active), and pull of pin i from bits [7+2i:6+2i]; pull_cfg presents pull of pin i at bits [2i+1:2i].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wkup_pin | input | 6 | Asynchronous wake-up pin levels, bit i is pin i |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target: 0 control, 1 mask A, 2 mask B, 3 flag clear |
| cfg_wdata | input | 18 | Write data |
| pull_cfg | output | 12 | Pull setting per pin for the pad ring |
| wake_flag | output | 6 | Sticky event flags |
| pin_irq | output | 6 | Per-pin interrupt lines, bit i is pin i |
| wake_req_a | output | 1 | Wake request to processor A |
| wake_req_b | output | 1 | Wake request to processor B |

## Verification
Every pin is tried with both polarities under each of the four mask combinations (none, A only, B only, both). This separates the edge direction from the polarity setting and shows that the two processors' requests are routed independently. It also shows that a fully masked pin records nothing. The flag is sampled one cycle before and exactly at its expected set edge to pin the synchroniser depth. It is then held at the active level after clearing, which tells edge detection from level detection. Separate patterns toggle polarity under a steady pin, collide a set with a clear, and sweep distinct pull codes across all pins to expose any field misplacement.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
   // Write-port targets
   typedef enum logic [1:0] {
      SEL_CTRL   = 2'd0,
      SEL_MASK_A = 2'd1,
      SEL_MASK_B = 2'd2,
      SEL_CLEAR  = 2'd3
   } wk_sel_e;

   // Active transition of a synchronised pin under a given polarity
   function automatic logic active_edge(input logic now_lvl, input logic prev_lvl,
                                        input logic high_act);
      return high_act ? (now_lvl & ~prev_lvl) : (~now_lvl & prev_lvl);
   endfunction
endpackage

// File: rtl/wkup_sync.sv
module wkup_sync #(
   parameter int WIDTH  = 6,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   initial assert (STAGES >= 2) else $error("wkup_sync: STAGES must be at least 2");
   initial assert (WIDTH >= 1) else $error("wkup_sync: WIDTH must be positive");

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d_async;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/wkup_edge_flag.sv
module wkup_edge_flag
   import wkup_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic pin_s,
   input  logic high_act,
   input  logic en_any,
   input  logic clr,
   output logic flag
);
   logic pin_prev;
   logic hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_prev <= 1'b0;
      else        pin_prev <= pin_s;
   end

   assign hit = en_any & active_edge(pin_s, pin_prev, high_act);

   // a fresh event outranks a simultaneous clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag <= 1'b0;
      else        flag <= hit | (flag & ~clr);
   end
endmodule

// File: rtl/wkup_pin_bank.sv
module wkup_pin_bank
   import wkup_pkg::*;
#(
   parameter int NUM_PINS    = 6,
   parameter int PULL_W      = 2,
   parameter int SYNC_STAGES = 2,
   localparam int CFG_W      = NUM_PINS * (1 + PULL_W),
   localparam int PULLS_W    = NUM_PINS * PULL_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] wkup_pin,
   input  logic                cfg_we,
   input  logic [1:0]          cfg_sel,
   input  logic [CFG_W-1:0]    cfg_wdata,
   output logic [PULLS_W-1:0]  pull_cfg,
   output logic [NUM_PINS-1:0] wake_flag,
   output logic [NUM_PINS-1:0] pin_irq,
   output logic                wake_req_a,
   output logic                wake_req_b
);
   initial assert (NUM_PINS >= 1 && NUM_PINS <= 32) else $error("wkup_pin_bank: NUM_PINS out of range");
   initial assert (PULL_W >= 1) else $error("wkup_pin_bank: PULL_W must be positive");

   wk_sel_e sel;
   assign sel = wk_sel_e'(cfg_sel);

   logic [NUM_PINS-1:0] pol_q, mask_a_q, mask_b_q, pin_s, clr_vec, en_any;
   logic [PULLS_W-1:0]  pull_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_q    <= '1;
         pull_q   <= '0;
         mask_a_q <= '0;
         mask_b_q <= '0;
      end else if (cfg_we) begin
         case (sel)
            SEL_CTRL: begin
               pol_q  <= cfg_wdata[NUM_PINS-1:0];
               pull_q <= cfg_wdata[CFG_W-1:NUM_PINS];
            end
            SEL_MASK_A: mask_a_q <= cfg_wdata[NUM_PINS-1:0];
            SEL_MASK_B: mask_b_q <= cfg_wdata[NUM_PINS-1:0];
            default: ;
         endcase
      end
   end

   assign clr_vec = (cfg_we && sel == SEL_CLEAR) ? cfg_wdata[NUM_PINS-1:0] : '0;
   assign en_any  = mask_a_q | mask_b_q;

   wkup_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (wkup_pin),
      .q_sync  (pin_s)
   );

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      wkup_edge_flag u_det (
         .clk      (clk),
         .rst_n    (rst_n),
         .pin_s    (pin_s[i]),
         .high_act (pol_q[i]),
         .en_any   (en_any[i]),
         .clr      (clr_vec[i]),
         .flag     (wake_flag[i])
      );
   end

   assign pin_irq    = wake_flag & en_any;
   assign wake_req_a = |(wake_flag & mask_a_q);
   assign wake_req_b = |(wake_flag & mask_b_q);
   assign pull_cfg   = pull_q;
endmodule

// File: rtl/wkup_pin_bank_chk.sv
module wkup_pin_bank_chk #(
   parameter int NUM_PINS = 6,
   parameter int PULL_W   = 2,
   localparam int CFG_W   = NUM_PINS * (1 + PULL_W)
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_PINS-1:0] pin_s,
   input logic [NUM_PINS-1:0] pol,
   input logic [NUM_PINS-1:0] mask_a,
   input logic [NUM_PINS-1:0] mask_b,
   input logic [NUM_PINS-1:0] flag,
   input logic [NUM_PINS-1:0] irq,
   input logic                wake_a,
   input logic                wake_b,
   input logic                cfg_we,
   input logic [1:0]          cfg_sel,
   input logic [CFG_W-1:0]    cfg_wdata
);
   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      // R4
      flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(flag[i]) |-> $past(cfg_we && cfg_sel == 2'd3 && cfg_wdata[i]));
      // R6
      flag_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flag[i]) |-> $past(mask_a[i] | mask_b[i]));
      // R2
      flag_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flag[i]) |-> ($past(pin_s[i]) == $past(pol[i])));
      // R9
      flag_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flag[i]) |-> ($past(pin_s[i]) != $past(pin_s[i], 2)));
      // R8
      irq_implies_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq[i] |-> flag[i]);
   end

   // R7
   wake_a_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_a) |-> ($past(cfg_we) || ($countones(flag) > $countones($past(flag)))));
   // R7
   wake_a_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wake_a) |-> $past(cfg_we));
   // R7
   wake_b_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wake_b) |-> $past(cfg_we));
endmodule

bind wkup_pin_bank wkup_pin_bank_chk #(.NUM_PINS(NUM_PINS), .PULL_W(PULL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pin_s     (pin_s),
   .pol       (pol_q),
   .mask_a    (mask_a_q),
   .mask_b    (mask_b_q),
   .flag      (wake_flag),
   .irq       (pin_irq),
   .wake_a    (wake_req_a),
   .wake_b    (wake_req_b),
   .cfg_we    (cfg_we),
   .cfg_sel   (cfg_sel),
   .cfg_wdata (cfg_wdata)
);

// File: tb/sim_wkup_pin_bank.sv
module sim_wkup_pin_bank;
   localparam int N  = 6;
   localparam int PW = 2;
   localparam int CW = N * (1 + PW);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pins = '0;
   logic          we = 1'b0;
   logic [1:0]    sel = '0;
   logic [CW-1:0] wdata = '0;
   logic [N*PW-1:0] pull_cfg;
   logic [N-1:0]  flags, irq;
   logic          wa, wb;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   wkup_pin_bank u0 (
      .clk(clk), .rst_n(rst_n), .wkup_pin(pins), .cfg_we(we), .cfg_sel(sel),
      .cfg_wdata(wdata), .pull_cfg(pull_cfg), .wake_flag(flags), .pin_irq(irq),
      .wake_req_a(wa), .wake_req_b(wb)
   );

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] s, input logic [CW-1:0] d);
      sel = s; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   function automatic logic [CW-1:0] ctrl_word(input logic [N-1:0] pol,
                                               input logic [N*PW-1:0] pulls);
      return {pulls, pol};
   endfunction

   initial begin
      step(3);
      // R1 reset state
      check(flags, 0, "R1 flags");
      check(irq, 0, "R1 irq");
      check({wa, wb}, 0, "R1 wake");
      check(pull_cfg, 0, "R1 pull");
      rst_n = 1'b1;
      step(2);
      // R1: default high polarity detects a rising edge once enabled
      wr(2'd1, CW'(1));
      pins[0] = 1'b1; step(3);
      check(flags, 1, "R1 default polarity");
      wr(2'd3, CW'(6'h3f)); pins[0] = 1'b0; step(4);

      // R2 R3 R6 R7 R8 R4: sweep pins x polarity x masks
      for (int i = 0; i < N; i++) begin
         for (int p = 0; p < 2; p++) begin
            for (int m = 0; m < 4; m++) begin
               logic [N-1:0] pol_v, bit_i, exp_f;
               bit_i = N'(1) << i;
               pol_v = '1;
               pol_v[i] = p[0];
               exp_f = (m != 0) ? bit_i : '0;
               wr(2'd1, '0);
               wr(2'd2, '0);
               wr(2'd0, ctrl_word(pol_v, '0));
               wr(2'd3, CW'(6'h3f));
               pins[i] = ~p[0];
               step(4);
               wr(2'd1, m[0] ? CW'(bit_i) : '0);
               wr(2'd2, m[1] ? CW'(bit_i) : '0);
               check(flags, 0, "R3 inactive transition");
               pins[i] = p[0];
               step(2);
               check(flags, 0, "R2 latency early");
               step(1);
               check(flags, exp_f, (m == 0) ? "R6 masked pin" : (p ? "R2 rising set" : "R3 falling set"));
               check(wa, (m[0] == 1'b1), "R7 wake A");
               check(wb, (m[1] == 1'b1), "R7 wake B");
               check(irq, exp_f, "R8 irq line");
               wr(2'd3, CW'(~bit_i));
               check(flags, exp_f, "R4 zero bits keep flag");
               wr(2'd3, CW'(bit_i));
               step(3);
               check(flags, 0, "R2 held level no reset");
               check({wa, wb}, 0, "R7 wake after clear");
               pins[i] = ~p[0];
               step(4);
               check(flags, 0, "R3 opposite edge");
            end
         end
      end

      // R9: polarity flips under a steady pin
      wr(2'd1, '0); wr(2'd2, '0);
      wr(2'd0, ctrl_word('1, '0));
      wr(2'd3, CW'(6'h3f));
      pins = 6'b000101; step(4);
      wr(2'd1, CW'(6'h3f)); wr(2'd2, CW'(6'h3f));
      wr(2'd0, ctrl_word('0, '0)); step(3);
      check(flags, 0, "R9 polarity to low");
      wr(2'd0, ctrl_word('1, '0)); step(3);
      check(flags, 0, "R9 polarity to high");

      // R5: set and clear collide
      pins[1] = 1'b1; step(2);
      sel = 2'd3; wdata = CW'(6'b000010); we = 1'b1;
      @(negedge clk); we = 1'b0;
      check(flags, 6'b000010, "R5 set beats clear");
      wr(2'd3, CW'(6'b000010));
      check(flags, 0, "R5 later clear");

      // R10: pull field sweep
      for (int v = 0; v < 4; v++) begin
         logic [N*PW-1:0] pulls;
         for (int k = 0; k < N; k++) pulls[k*PW +: PW] = PW'((v + k) % 4);
         wr(2'd0, ctrl_word('1, pulls));
         check(pull_cfg, pulls, "R10 pull layout");
      end
      check(flags, 0, "R10 ctrl write no flag");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule